// File: doc/BRIEF.md
# Computation Unit Operand Manager

This block follows one operation through a computation unit, from the cycle it is issued until its result has been written back. The issue stage presents an opcode with its modifier flags (invert operand A, force operand A to zero, immediate value and its valid flag) and a two-bit read mask, and pulses `issue_i`. The block latches all of these and raises `busy_o`. For each source operand it needs, it raises a read request toward the register file. It then waits for a one-cycle go pulse that carries the operand on that port's source bus.

When both operands are in hand, the block hands them to an internal multi-cycle ALU through a valid/ready handshake. The ALU result is parked behind a write request and shown on `data_o` until the write-back side acknowledges it with a one-cycle go pulse. Only then does `busy_o` fall. A result is never dropped, and nothing is re-requested within one operation.

Top module: `cu_operand_mgr`

## Requirements
- R1: After reset `busy_o`, `rd_rel_o` and `wr_rel_o` are low. `busy_o` stays low in any cycle that follows a cycle with both `busy_o` and `issue_i` low. An issue is only accepted while `busy_o` is low, so `busy_o` is never high in an accepted issue cycle.
- R2: Opcode, flags, immediate and read mask are captured in the issue cycle. Changing those inputs in later cycles does not change the result.
- R3: A needed read request `rd_rel_o[p]` is low in the issue cycle and high in the cycle after it.
- R4: A read request stays high through any number of stall cycles and falls in the cycle after its `rd_go_i[p]` was high. A go asserted in the very first cycle of the request is accepted. The operand taken is the value on that port's source bus in the go cycle.
- R5: Port A (bit 0) raises no request when zero-A is set or read-mask bit 0 is set. Port B (bit 1) raises no request when immediate-valid is set or read-mask bit 1 is set. A masked port without an override supplies 0.
- R6: With zero-A set, operand A is 0. With immediate-valid set, operand B is the latched immediate.
- R7: With invert-A set, operand A is bitwise inverted before the ALU. For example, add with A=5, B=2 gives 65532.
- R8: Opcode 0 computes A+B, 1 computes A-B, 2 computes A AND B and 3 computes A XOR B. All results are modulo 2^16.
- R9: Once the ALU result is available, `wr_rel_o` rises. `data_o` carries the result and stays stable while `wr_rel_o` is high.
- R10: In the cycle after `wr_go_i` is high together with `wr_rel_o`, both `wr_rel_o` and `busy_o` are low. Go pulses on a port with no pending request are ignored. A read request does not re-assert before a new issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Issue strobe |
| op_i | input | 2 | ALU opcode (0 add, 1 sub, 2 and, 3 xor) |
| inv_a_i | input | 1 | Invert operand A |
| zero_a_i | input | 1 | Force operand A to zero, no read for A |
| imm_i | input | 16 | Immediate value |
| imm_ok_i | input | 1 | Immediate replaces operand B, no read for B |
| rdmask_i | input | 2 | Per-port read suppression (bit 0 A, bit 1 B) |
| busy_o | output | 1 | Operation in flight |
| rd_rel_o | output | 2 | Read requests (bit 0 A, bit 1 B) |
| rd_go_i | input | 2 | Read go pulses (bit 0 A, bit 1 B) |
| src_a_i | input | 16 | Operand A bus, sampled in go cycle |
| src_b_i | input | 16 | Operand B bus, sampled in go cycle |
| wr_rel_o | output | 1 | Write request, result ready |
| wr_go_i | input | 1 | Write go pulse |
| data_o | output | 16 | Result |

## Verification
A source-port flag left in the wrong state shows at the port in one of two ways. Either the request never drops, which the bench sees one cycle after its go pulse, or a request appears for a suppressed port in the cycle after issue. A wrong latched field or a wrong operand capture shows as a wrong `data_o` in the first cycle of `wr_rel_o`, a few cycles after the last go. A stuck busy or launch flag shows either as `busy_o` remaining high one cycle after the write go, or as `wr_rel_o` never arriving within the bench's 60-cycle wait. The sweep runs every opcode and flag and mask combination, so each suppression path and each operand substitution reaches the result.

// File: rtl/cu_pkg.sv
// Shared types for the computation-unit operand manager.
package cu_pkg;
    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_XOR = 2'd3
    } alu_op_e;

    // Control fields captured at issue
    typedef struct packed {
        alu_op_e    op;
        logic       inv_a;
    } ctrl_t;
endpackage

// File: rtl/cu_src_port.sv
// One source-operand port: holds a read request open until its go pulse,
// capturing the operand bus in the go cycle.
// Assumes start_i is only pulsed while the unit is idle.
module cu_src_port #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         need_i,
    input  logic [W-1:0] fill_i,
    input  logic         go_i,
    input  logic [W-1:0] src_i,
    output logic         rel_o,
    output logic         got_o,
    output logic [W-1:0] opnd_o
);
    logic         got_q;
    logic [W-1:0] opnd_q;

    // Request/capture state: open at start if needed, close on go
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_q  <= 1'b1;
            opnd_q <= '0;
        end else if (start_i) begin
            got_q  <= ~need_i;
            opnd_q <= fill_i;
        end else if (go_i && !got_q) begin
            got_q  <= 1'b1;
            opnd_q <= src_i;
        end
    end

    assign rel_o  = ~got_q;
    assign got_o  = got_q;
    assign opnd_o = opnd_q;

    a_r4_rel_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_o && !go_i) |=> rel_o);
    a_r4_rel_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_o && go_i) |=> !rel_o);
    a_r3_rel_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!rel_o && !start_i) |=> !rel_o);
endmodule

// File: rtl/cu_alu.sv
// Multi-cycle ALU with valid/ready on both sides. Accepts one operation
// when idle, produces the result LAT cycles later and holds it until taken.
module cu_alu
    import cu_pkg::*;
#(
    parameter int W   = 16,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid_i,
    output logic         in_ready_o,
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         out_valid_o,
    input  logic         out_ready_i,
    output logic [W-1:0] res_o
);
    localparam int CW = (LAT < 1) ? 1 : $clog2(LAT + 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  res_q;
    logic [W-1:0]  res_d;

    // Combinational operation select
    always_comb begin
        unique case (op_i)
            ALU_ADD: res_d = a_i + b_i;
            ALU_SUB: res_d = a_i - b_i;
            ALU_AND: res_d = a_i & b_i;
            default: res_d = a_i ^ b_i;
        endcase
    end

    // Accept, count down latency, release on output handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            res_q  <= '0;
        end else if (!busy_q) begin
            if (in_valid_i) begin
                busy_q <= 1'b1;
                cnt_q  <= CW'(LAT);
                res_q  <= res_d;
            end
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (out_ready_i) begin
            busy_q <= 1'b0;
        end
    end

    assign in_ready_o  = ~busy_q;
    assign out_valid_o = busy_q && (cnt_q == '0);
    assign res_o       = res_q;

    a_r9_alu_res_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(res_o)));
endmodule

// File: rtl/cu_wb_stage.sv
// Write-back holding stage: parks the ALU result behind a write request
// until the one-cycle write go arrives.
module cu_wb_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         res_valid_i,
    input  logic [W-1:0] res_i,
    output logic         res_ready_o,
    input  logic         wr_go_i,
    output logic         wr_rel_o,
    output logic [W-1:0] data_o,
    output logic         done_o
);
    logic         rel_q;
    logic [W-1:0] data_q;

    // Capture result when empty, release on write go
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_q  <= 1'b0;
            data_q <= '0;
        end else if (!rel_q) begin
            if (res_valid_i) begin
                rel_q  <= 1'b1;
                data_q <= res_i;
            end
        end else if (wr_go_i) begin
            rel_q <= 1'b0;
        end
    end

    assign res_ready_o = ~rel_q;
    assign wr_rel_o    = rel_q;
    assign data_o      = data_q;
    assign done_o      = rel_q & wr_go_i;

    a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rel_o && !wr_go_i) |=> (wr_rel_o && $stable(data_o)));
endmodule

// File: rtl/cu_operand_mgr.sv
// Computation-unit operand manager: latches an issued operation, collects
// its source operands through per-port request/go handshakes, runs the ALU
// and holds the result until the write go. busy_o spans issue to write go.
// Assumes the issue stage only issues while busy_o is low.
module cu_operand_mgr
    import cu_pkg::*;
#(
    parameter int W   = 16,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue_i,
    input  logic [1:0]   op_i,
    input  logic         inv_a_i,
    input  logic         zero_a_i,
    input  logic [W-1:0] imm_i,
    input  logic         imm_ok_i,
    input  logic [1:0]   rdmask_i,
    output logic         busy_o,
    output logic [1:0]   rd_rel_o,
    input  logic [1:0]   rd_go_i,
    input  logic [W-1:0] src_a_i,
    input  logic [W-1:0] src_b_i,
    output logic         wr_rel_o,
    input  logic         wr_go_i,
    output logic [W-1:0] data_o
);
    localparam int NSRC = 2;

    logic            busy_q;
    logic            launched_q;
    ctrl_t           ctrl_q;
    logic            start;
    logic            done;
    logic [NSRC-1:0] need;
    logic [NSRC-1:0] got;
    logic [W-1:0]    fill [NSRC];
    logic [W-1:0]    src  [NSRC];
    logic [W-1:0]    opnd [NSRC];
    logic            alu_in_valid;
    logic            alu_in_ready;
    logic            alu_out_valid;
    logic            alu_out_ready;
    logic [W-1:0]    alu_res;
    logic [W-1:0]    alu_a;

    assign start = issue_i & ~busy_q;

    // Per-port need and fill value decoded from the issue-cycle inputs
    always_comb begin
        need[0] = ~(zero_a_i | rdmask_i[0]);
        need[1] = ~(imm_ok_i | rdmask_i[1]);
        fill[0] = '0;
        fill[1] = imm_ok_i ? imm_i : '0;
        src[0]  = src_a_i;
        src[1]  = src_b_i;
    end

    for (genvar p = 0; p < NSRC; p++) begin : g_src
        cu_src_port #(.W(W)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .start_i(start),
            .need_i (need[p]),
            .fill_i (fill[p]),
            .go_i   (rd_go_i[p]),
            .src_i  (src[p]),
            .rel_o  (rd_rel_o[p]),
            .got_o  (got[p]),
            .opnd_o (opnd[p])
        );
    end

    // Operation lifetime: busy from accepted issue to write go
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            launched_q <= 1'b0;
            ctrl_q     <= '{op: ALU_ADD, inv_a: 1'b0};
        end else if (start) begin
            busy_q     <= 1'b1;
            launched_q <= 1'b0;
            ctrl_q     <= '{op: alu_op_e'(op_i), inv_a: inv_a_i};
        end else begin
            if (alu_in_valid && alu_in_ready) launched_q <= 1'b1;
            if (done) busy_q <= 1'b0;
        end
    end

    assign alu_in_valid = busy_q & (&got) & ~launched_q;
    assign alu_a        = ctrl_q.inv_a ? ~opnd[0] : opnd[0];

    cu_alu #(.W(W), .LAT(LAT)) u_alu (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (alu_in_valid),
        .in_ready_o (alu_in_ready),
        .op_i       (ctrl_q.op),
        .a_i        (alu_a),
        .b_i        (opnd[1]),
        .out_valid_o(alu_out_valid),
        .out_ready_i(alu_out_ready),
        .res_o      (alu_res)
    );

    cu_wb_stage #(.W(W)) u_wb (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_valid_i(alu_out_valid),
        .res_i      (alu_res),
        .res_ready_o(alu_out_ready),
        .wr_go_i    (wr_go_i),
        .wr_rel_o   (wr_rel_o),
        .data_o     (data_o),
        .done_o     (done)
    );

    assign busy_o = busy_q;

    a_r1_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !issue_i) |=> !busy_o);
    a_r10_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rel_o && wr_go_i) |=> (!busy_o && !wr_rel_o));
    a_r10_no_rel_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (rd_rel_o == 2'b00 && !wr_rel_o));
    a_r3_issue_cycle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (rd_rel_o == 2'b00));
endmodule

// File: tb/sim_cu_operand_mgr.sv
module sim_cu_operand_mgr;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue_i = 1'b0;
    logic [1:0]   op_i = '0;
    logic         inv_a_i = 1'b0;
    logic         zero_a_i = 1'b0;
    logic [W-1:0] imm_i = '0;
    logic         imm_ok_i = 1'b0;
    logic [1:0]   rdmask_i = '0;
    logic         busy_o;
    logic [1:0]   rd_rel_o;
    logic [1:0]   rd_go_i = '0;
    logic [W-1:0] src_a_i = '0;
    logic [W-1:0] src_b_i = '0;
    logic         wr_rel_o;
    logic         wr_go_i = 1'b0;
    logic [W-1:0] data_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cu_operand_mgr #(.W(W), .LAT(2)) u0 (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
        .inv_a_i(inv_a_i), .zero_a_i(zero_a_i), .imm_i(imm_i),
        .imm_ok_i(imm_ok_i), .rdmask_i(rdmask_i), .busy_o(busy_o),
        .rd_rel_o(rd_rel_o), .rd_go_i(rd_go_i), .src_a_i(src_a_i),
        .src_b_i(src_b_i), .wr_rel_o(wr_rel_o), .wr_go_i(wr_go_i),
        .data_o(data_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [W-1:0] expect_res(input logic [1:0] op, input logic inv,
        input logic za, input logic iok, input logic [1:0] msk,
        input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] imm);
        logic [W-1:0] ea, eb;
        ea = (za || msk[0]) ? '0 : a;
        eb = iok ? imm : (msk[1] ? '0 : b);
        if (inv) ea = ~ea;
        case (op)
            2'd0: return ea + eb;
            2'd1: return ea - eb;
            2'd2: return ea & eb;
            default: return ea ^ eb;
        endcase
    endfunction

    // One complete operation with given stall delays
    task automatic run_op(input logic [1:0] op, input logic inv, input logic za,
        input logic iok, input logic [1:0] msk, input logic [W-1:0] a,
        input logic [W-1:0] b, input logic [W-1:0] imm,
        input int da, input int db, input int dw);
        logic [1:0] need;
        logic [W-1:0] exp, first;
        int d [2];
        int t;
        need[0] = !(za || msk[0]);
        need[1] = !(iok || msk[1]);
        d[0] = da; d[1] = db;
        exp = expect_res(op, inv, za, iok, msk, a, b, imm);
        // issue cycle
        issue_i = 1'b1; op_i = op; inv_a_i = inv; zero_a_i = za;
        imm_i = imm; imm_ok_i = iok; rdmask_i = msk;
        check("R1 busy low in issue cycle", busy_o, 0);
        check("R3 no request in issue cycle", rd_rel_o, 0);
        @(negedge clk); cyc++;
        // R2: scramble the fields after issue
        issue_i = 1'b0; op_i = ~op; inv_a_i = ~inv; zero_a_i = ~za;
        imm_i = ~imm; imm_ok_i = ~iok; rdmask_i = ~msk;
        check("R1 busy after issue", busy_o, 1);
        check("R3 R5 requests one cycle after issue", rd_rel_o, need);
        for (int k = 0; k <= 5; k++) begin
            for (int p = 0; p < 2; p++) begin
                if (need[p]) begin
                    if (k <= d[p]) check("R4 request held until go", rd_rel_o[p], 1);
                    if (k == d[p] + 1) check("R4 request falls after go", rd_rel_o[p], 0);
                    rd_go_i[p] = (k == d[p]);
                end else begin
                    check("R5 suppressed port quiet", rd_rel_o[p], 0);
                    rd_go_i[p] = k[0];   // R10 stray go ignored
                end
            end
            src_a_i = (need[0] && k == d[0]) ? a : ~a;
            src_b_i = (need[1] && k == d[1]) ? b : ~b;
            @(negedge clk); cyc++;
        end
        rd_go_i = '0;
        t = 0;
        while (!wr_rel_o && t < 60) begin
            check("R10 no request re-assert", rd_rel_o, 0);
            wr_go_i = t[0];      // R10 write go without request ignored
            @(negedge clk); cyc++; t++;
        end
        wr_go_i = 1'b0;
        check("R9 write request raised", wr_rel_o, 1);
        check("R8 R6 R7 R2 result", data_o, exp);
        check("R10 busy held while result waits", busy_o, 1);
        first = data_o;
        for (int k = 0; k < dw; k++) begin
            @(negedge clk); cyc++;
            check("R9 request held", wr_rel_o, 1);
            check("R9 data stable", data_o, first);
        end
        wr_go_i = 1'b1;
        @(negedge clk); cyc++;
        wr_go_i = 1'b0;
        check("R10 write request drops", wr_rel_o, 0);
        check("R10 busy drops", busy_o, 0);
        check("R10 read requests idle", rd_rel_o, 0);
        @(negedge clk); cyc++;
        check("R1 busy stays low without issue", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset busy", busy_o, 0);
        check("R1 reset rd_rel", rd_rel_o, 0);
        check("R1 reset wr_rel", wr_rel_o, 0);
        // R7 worked example, R4 go in first request cycle
        run_op(2'd0, 1'b1, 1'b0, 1'b0, 2'b00, 16'd5, 16'd2, 16'd0, 0, 0, 0);
        check("R7 invert example", 32'(expect_res(2'd0, 1'b1, 1'b0, 1'b0, 2'b00, 16'd5, 16'd2, 16'd0)), 32'd65532);
        for (int i = 0; i < 128; i++) begin
            run_op(2'(i), i[2], i[3], i[4], 2'(i >> 5),
                   16'(i * 37 + 5), 16'(i * 91 + 2), 16'(i * 13 + 8),
                   i % 4, (i / 4) % 3, i % 3);
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule